// File: doc/BRIEF.md
# Grouped Series-Parallel Carry Counter

A synchronous binary up-counter whose width is split into four-bit groups. Every flop runs from the same clock, so a count step reaches every stage on the same edge. Inside a group, each bit decides on its own whether to toggle. It toggles when the incoming group carry is active and all lower bits of that group are one. Between groups, one AND stage per group forms the carry into the next group. That carry is active only when the group's own carry is active and all four of its bits are one.

Cascading is controlled by two inputs: a count enable and a carry enable. The counter steps only when both are high. The carry-out is the last link of the inter-group AND chain. It therefore signals that the count is all ones and that the next enabled edge wraps the count to zero. A wider counter can take this output as its carry enable. The number of groups is a parameter. The worst-case settle path is one AND stage per group boundary plus the settle time of one group.

Top module: `grouped_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes zero on that edge, whatever the enables are.
- R2: When `count_en` and `carry_en` are both high at an edge and `rst` is low, `count` becomes its previous value plus one, modulo 2^(4*NUM_GROUPS).
- R3: When `count_en` is low at an edge and `rst` is low, `count` keeps its value.
- R4: When `carry_en` is low, `count` keeps its value at the edge and `carry_out` is low.
- R5: `carry_out` is high in the same cycle exactly when `count` is all ones and both `count_en` and `carry_en` are high.
- R6: An enabled step from all ones gives all zeros.
- R7: Bits of group k (bits 4k+3..4k, k at least 1) change only on an edge at which all bits below bit 4k were one.
- R8: Within a group, no bit changes on an edge at which that group's incoming carry was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all flops update on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| count_en | input | 1 | Count enable |
| carry_en | input | 1 | Carry enable for cascading |
| count | output | 4*NUM_GROUPS | Current count, bit 0 least significant |
| carry_out | output | 1 | High when the count is all ones and both enables are high |

## Verification
`count` is registered and takes its new value on the first rising edge after the inputs are applied. The bench drives inputs on the falling edge and reads `count` 1 ns after the next rising edge. `carry_out` is combinational from the current count and the enables. It is therefore read 1 ns after the falling edge that applies the inputs, before the edge that would change the count. Both the table walk and the full-wrap runs for two and three groups follow this timing.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
    localparam int GROUP_W = 4;
    typedef logic [GROUP_W-1:0] grp_t;
endpackage

// File: rtl/gcnt_carry_chain.sv
// Serial AND chain between groups: stage k+1 carry = stage k carry AND group k full.
module gcnt_carry_chain #(
    parameter int NUM_GROUPS = 2
) (
    input  logic                  chain_in,
    input  logic [NUM_GROUPS-1:0] grp_full,
    output logic [NUM_GROUPS:0]   grp_cin
);
    assign grp_cin[0] = chain_in;
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_link
        assign grp_cin[k+1] = grp_cin[k] & grp_full[k];
    end
endmodule

// File: rtl/gcnt_group.sv
// One four-bit section: every bit forms its own toggle term in parallel.
module gcnt_group
    import gcnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grp_cin,
    output grp_t q,
    output logic grp_full
);
    grp_t tog;

    for (genvar i = 0; i < GROUP_W; i++) begin : g_tog
        if (i == 0) begin : g_lsb
            assign tog[i] = grp_cin;
        end else begin : g_upper
            assign tog[i] = grp_cin & (&q[i-1:0]);
        end
    end

    assign grp_full = &q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q ^ tog;
    end

    // R8: a group with no incoming carry holds
    a_r8_group_hold: assert property (@(posedge clk) disable iff (rst)
        !grp_cin |=> $stable(q));
endmodule

// File: rtl/grouped_counter.sv
module grouped_counter
    import gcnt_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            count_en,
    input  logic                            carry_en,
    output logic [NUM_GROUPS*GROUP_W-1:0]   count,
    output logic                            carry_out
);
    localparam int CNT_W = NUM_GROUPS * GROUP_W;

    logic [NUM_GROUPS-1:0] full;
    logic [NUM_GROUPS:0]   cin;

    gcnt_carry_chain #(.NUM_GROUPS(NUM_GROUPS)) u_chain (
        .chain_in (count_en & carry_en),
        .grp_full (full),
        .grp_cin  (cin)
    );

    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
        grp_t q_k;
        gcnt_group u_grp (
            .clk      (clk),
            .rst      (rst),
            .grp_cin  (cin[k]),
            .q        (q_k),
            .grp_full (full[k])
        );
        assign count[k*GROUP_W +: GROUP_W] = q_k;

        if (k > 0) begin : g_chk
            // R7: an upper group moves only after all lower bits were one
            a_r7_group_carry: assert property (@(posedge clk) disable iff (rst)
                (count[k*GROUP_W +: GROUP_W] != $past(count[k*GROUP_W +: GROUP_W]))
                |-> (&$past(count[k*GROUP_W-1:0])));
        end
    end

    assign carry_out = cin[NUM_GROUPS];

    // R1: synchronous clear
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (count == '0));
    // R2 / R6: enabled step adds one, wrapping
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (count_en && carry_en) |=> (count == CNT_W'($past(count) + 1'b1)));
    // R3: no count enable, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(count));
    // R4: carry enable low blocks carry-out and counting
    a_r4_carry_gate: assert property (@(posedge clk) disable iff (rst)
        !carry_en |-> (!carry_out ##1 $stable(count)));
    // R5: carry-out only at all ones
    a_r5_carry_out: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (&count));
endmodule

// File: tb/grouped_counter_tb.sv
module grouped_counter_tb;
    localparam real CLK_NS = 8.0;

    logic clk = 1'b0;
    logic rst, cen, ken;
    logic [7:0]  cnt2;
    logic [11:0] cnt3;
    logic        co2, co3;
    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    grouped_counter #(.NUM_GROUPS(2)) u_dut (
        .clk(clk), .rst(rst), .count_en(cen), .carry_en(ken),
        .count(cnt2), .carry_out(co2));
    grouped_counter #(.NUM_GROUPS(3)) u_dut3 (
        .clk(clk), .rst(rst), .count_en(cen), .carry_en(ken),
        .count(cnt3), .carry_out(co3));

    // {rst, count_en, carry_en, expected 8-bit count after the edge}
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {3'b100, 8'h00},   // R1
        {3'b011, 8'h01},   // R2
        {3'b011, 8'h02},   // R2
        {3'b001, 8'h02},   // R3
        {3'b010, 8'h02},   // R4
        {3'b000, 8'h02},   // R3
        {3'b011, 8'h03},   // R2
        {3'b111, 8'h00},   // R1 beats enables
        {3'b011, 8'h01},   // R2
        {3'b101, 8'h00}    // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic c, input logic k);
        @(negedge clk);
        rst = r; cen = c; ken = k;
        #1;
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  m2;
        logic [11:0] m3;
        rst = 1'b1; cen = 1'b0; ken = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset state", cnt2, 0);
        chk("R1 reset state 3g", cnt3, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8]);
            @(posedge clk); #1;
            chk("R1/R2/R3/R4 table", cnt2, VEC[i][7:0]);
        end

        // full wrap, both widths, against a +1 model (R2, R5, R6, R7, R8)
        step(1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        m2 = '0; m3 = '0;
        for (int i = 0; i < 4097; i++) begin
            step(1'b0, 1'b1, 1'b1);
            if (i < 257) chk("R5 carry_out 2g", co2, (m2 == 8'hFF));
            chk("R5 carry_out 3g", co3, (m3 == 12'hFFF));
            @(posedge clk); #1;
            m2 = m2 + 1'b1; m3 = m3 + 1'b1;
            if (i < 257) chk("R2 R6 R7 count 2g", cnt2, m2);
            if (i % 64 == 0 || m3 == 12'h000 || m3 == 12'h100)
                chk("R2 R6 R7 count 3g", cnt3, m3);
        end
        chk("R6 wrap 3g", cnt3, 12'h001);

        // drive 2-group to all ones, then probe the enables (R4, R5, R8)
        step(1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        for (int i = 0; i < 255; i++) begin
            step(1'b0, 1'b1, 1'b1);
            @(posedge clk); #1;
        end
        chk("R6 reached all ones", cnt2, 8'hFF);
        step(1'b0, 1'b1, 1'b0);
        chk("R4 carry_out low with carry_en low", co2, 0);
        @(posedge clk); #1;
        chk("R4 hold at all ones", cnt2, 8'hFF);
        step(1'b0, 1'b0, 1'b1);
        chk("R5 carry_out low with count_en low", co2, 0);
        @(posedge clk); #1;
        chk("R3 R8 hold at all ones", cnt2, 8'hFF);
        step(1'b0, 1'b1, 1'b1);
        chk("R5 carry_out high at all ones", co2, 1);
        @(posedge clk); #1;
        chk("R6 wrap to zero", cnt2, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule